// File: doc/BRIEF.md
# Interrupt Request Combiner

This block gathers a set of interrupt request lines, up to 32 of them, and folds them into one interrupt output for a host processor. Each line is programmed on its own. A polarity bit selects active-high or rising against active-low or falling. A type bit selects a level-sensitive or an edge-sensitive input. An enable bit decides whether the line can reach the output. Edge-sensitive lines capture their event in a pending bit, which holds until software writes a one to the acknowledge address. Level-sensitive lines follow the request pin directly once polarity is applied.

Software reaches the block over a simple single-cycle register bus. A write takes effect at the clock edge on which `reg_wr` is high. Reads are combinational from `reg_addr`. The enable mask can be written whole, or individual bits can be set or cleared through two companion addresses. Two read-only addresses identify the block: one reports a fixed revision word, and the other reports how many request lines are implemented. The request inputs are assumed to be synchronous to `clk` already.

Word addresses: 0 polarity, 1 type, 2 enable (whole), 3 enable-set, 4 enable-clear, 5 acknowledge, 6 raw status, 7 enabled status, 8 options, 9 revision. Reads of 3 and 4 return the enable mask. Reads of 5 and of any unlisted address return zero.

Top module: `irq_merge_ctrl`

## Requirements
- R1: After reset, the polarity, type, enable and pending state are all zero, `irq_out` is low, and raw status reads zero while all requests are low.
- R2: Reading address 8 returns the number of request lines (parameter NUM_IN) in bits [5:0], with every other bit zero.
- R3: Reading address 9 returns the parameter VERSION unchanged.
- R4: For a line whose type bit is 0 (level), its raw status bit (address 6) equals the request pin XOR its polarity bit, in the same cycle and with no clocking.
- R5: For a line whose type bit is 1 (edge), the pending bit is set at the clock edge where the sampled request differs from the value sampled one edge earlier in the direction the polarity selects. Polarity 0 selects low-to-high and polarity 1 selects high-to-low. The bit shows in raw status after that edge. An edge line's raw bit is its pending bit only.
- R6: A pending bit stays set until a write to address 5 has a one in that bit position. Zeros in the acknowledge word leave pending bits unchanged.
- R7: When an acknowledge write and a new selected edge fall on the same line at the same clock edge, the line remains pending.
- R8: A write to address 3 sets the enable bits where the data has ones. A write to address 4 clears them. A write to address 2 replaces the mask. All other enable bits are kept.
- R9: `irq_out` is high exactly when the AND of raw status and enable is nonzero. Address 7 returns that AND.
- R10: Bits at or above NUM_IN read as zero at addresses 0 to 7, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | NUM_IN | Synchronous interrupt request lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_out | output | 1 | Combined interrupt output |

## Verification
The acknowledge write and the capture of a fresh edge can both hit the same pending bit at one clock edge. The bench provokes this by driving an acknowledge word on the same negative edge that it changes the request vector, in every edge-type configuration. Its own pending model gives the edge priority, so a line both cleared and re-triggered must read back as set. The raw-status read and `irq_out` in the following cycle are compared against that model.

// File: rtl/irq_merge_ctrl.sv
module irq_merge_ctrl #(
  parameter int          NUM_IN  = 8,
  parameter logic [31:0] VERSION = 32'h0230_5A17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irq_req,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_out
);

  localparam logic [3:0] A_POL = 4'd0, A_TYPE = 4'd1, A_EN = 4'd2, A_SET = 4'd3,
                         A_CLR = 4'd4, A_ACK = 4'd5, A_RAW = 4'd6, A_ACT = 4'd7,
                         A_OPT = 4'd8, A_VER = 4'd9;

  logic [NUM_IN-1:0] pol_q, type_q, en_q, pend_q, prev_q;
  logic [NUM_IN-1:0] wdat, edge_hit, level_on, raw, ack_m, rd_vec;
  logic              wr_pol, wr_type, wr_en, wr_set, wr_clr, wr_ack, rd_small;

  assign wdat    = reg_wdata[NUM_IN-1:0];
  assign wr_pol  = reg_wr && reg_addr == A_POL;
  assign wr_type = reg_wr && reg_addr == A_TYPE;
  assign wr_en   = reg_wr && reg_addr == A_EN;
  assign wr_set  = reg_wr && reg_addr == A_SET;
  assign wr_clr  = reg_wr && reg_addr == A_CLR;
  assign wr_ack  = reg_wr && reg_addr == A_ACK;
  assign ack_m   = wr_ack ? wdat : '0;

  assign edge_hit = type_q & ((~pol_q & irq_req & ~prev_q) | (pol_q & ~irq_req & prev_q));
  assign level_on = ~type_q & (irq_req ^ pol_q);
  assign raw      = (pend_q & type_q) | level_on;
  assign irq_out  = |(raw & en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= '0;
      type_q <= '0;
      en_q   <= '0;
      pend_q <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= irq_req;
      if (wr_pol)  pol_q  <= wdat;
      if (wr_type) type_q <= wdat;
      if (wr_en)       en_q <= wdat;
      else if (wr_set) en_q <= en_q | wdat;
      else if (wr_clr) en_q <= en_q & ~wdat;
      pend_q <= ((pend_q & ~ack_m) | edge_hit) & type_q;
    end
  end

  always_comb begin
    rd_small = 1'b1;
    unique case (reg_addr)
      A_POL:         rd_vec = pol_q;
      A_TYPE:        rd_vec = type_q;
      A_EN, A_SET,
      A_CLR:         rd_vec = en_q;
      A_RAW:         rd_vec = raw;
      A_ACT:         rd_vec = raw & en_q;
      default: begin rd_vec = '0; rd_small = (reg_addr == A_ACK); end
    endcase
    reg_rdata = '0;
    reg_rdata[NUM_IN-1:0] = rd_vec;
    if (!rd_small) begin
      if (reg_addr == A_OPT)      reg_rdata = {26'd0, 6'(NUM_IN)};
      else if (reg_addr == A_VER) reg_rdata = VERSION;
    end
  end

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> (pend_q & $past(wdat & ~edge_hit)) == '0); // R6

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> (pend_q & $past(edge_hit)) == $past(edge_hit)); // R7

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> (en_q & $past(wdat)) == $past(wdat)); // R8

  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> (en_q & $past(wdat)) == '0); // R8

  AST_QUIET_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    en_q == '0 |-> !irq_out); // R9

  AST_PEND_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) == 1'b0 |=> (pend_q & ~$past(pend_q)) == '0); // R5

  generate
    if (NUM_IN < 32) begin : g_hi
      AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr < A_OPT |-> reg_rdata[31:NUM_IN] == '0); // R10
    end
  endgenerate

endmodule

// File: tb/test_irq_merge_ctrl.sv
`timescale 1ns/100ps
module test_irq_merge_ctrl;
  localparam int          N   = 8;
  localparam logic [31:0] VER = 32'h0230_5A17;

  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [N-1:0] irq_req = '0;
  logic [3:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0, reg_rdata;
  logic         irq_out;

  int n_run = 0, n_fail = 0;
  logic [N-1:0] m_pol, m_type, m_en, m_pend, m_prev;

  irq_merge_ctrl #(.NUM_IN(N), .VERSION(VER)) i_irq_merge_ctrl (
    .clk, .rst_n, .irq_req, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata, .irq_out);

  always #2 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1; reg_wr = 0;
  endtask

  function automatic logic [N-1:0] exp_raw(logic [N-1:0] v);
    return (m_pend & m_type) | (~m_type & (v ^ m_pol));
  endfunction

  task automatic step(logic [N-1:0] v, logic [N-1:0] ack, string tag);
    logic [N-1:0] hit;
    logic [31:0]  d;
    @(negedge clk);
    irq_req = v;
    if (ack != 0) begin reg_wr = 1; reg_addr = 4'd5; reg_wdata = 32'(ack); end
    @(posedge clk);
    hit = m_type & ((~m_pol & v & ~m_prev) | (m_pol & ~v & m_prev));
    m_pend = ((m_pend & ~ack) | hit) & m_type;
    m_prev = v;
    #1; reg_wr = 0;
    rd(4'd6, d);
    chk(ack != 0 ? "R7" : tag, d, 32'(exp_raw(v)));
    chk("R9", 32'(irq_out), 32'(|(exp_raw(v) & m_en)));
    rd(4'd7, d);
    chk("R9", d, 32'(exp_raw(v) & m_en));
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [N-1:0] cp [5] = '{8'h00, 8'hFF, 8'h00, 8'hFF, 8'h3C};
    logic [N-1:0] ct [5] = '{8'h00, 8'h00, 8'hFF, 8'hFF, 8'hA6};
    logic [N-1:0] ce [5] = '{8'hFF, 8'h5A, 8'hFF, 8'hC3, 8'hFF};
    m_pol = '0; m_type = '0; m_en = '0; m_pend = '0; m_prev = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin rd(4'(a), d); chk("R1", d, 0); end
    chk("R1", 32'(irq_out), 0);
    rd(4'd8, d); chk("R2", d, N);
    rd(4'd9, d); chk("R3", d, VER);

    // R8 enable set/clear/replace, R10 upper bits ignored
    wr(4'd3, 32'hFFFF_0011); rd(4'd3, d); chk("R8", d, 32'h11);
    wr(4'd3, 32'h0000_0084); rd(4'd2, d); chk("R8", d, 32'h95);
    wr(4'd4, 32'hFFFF_0010); rd(4'd4, d); chk("R8", d, 32'h85);
    wr(4'd2, 32'hABCD_0042); rd(4'd2, d); chk("R8", d, 32'h42);
    wr(4'd0, 32'hFFFF_FF00); rd(4'd0, d); chk("R10", d, 0);
    wr(4'd1, 32'h5500_0000); rd(4'd1, d); chk("R10", d, 0);
    rd(4'd5, d); chk("R10", d, 0);

    // Sweep configurations
    for (int c = 0; c < 5; c++) begin
      wr(4'd0, 32'(cp[c])); m_pol = cp[c];
      wr(4'd1, 32'(ct[c])); m_type = ct[c];
      wr(4'd2, 32'(ce[c])); m_en = ce[c];
      wr(4'd5, 32'hFF); m_pend = '0;
      for (int k = 0; k < 40; k++) begin
        logic [N-1:0] v, a;
        v = N'((k * 29 + c * 11 + 3) ^ (k >> 2));
        a = (k % 3 == 2) ? N'(8'h33 << (k % 4)) : '0;
        step(v, a, ct[c] == 0 ? "R4" : "R5");
      end
    end

    // R6 pending held until its own bit is acknowledged
    wr(4'd0, 0); m_pol = '0;
    wr(4'd1, 32'hFF); m_type = '1;
    wr(4'd2, 32'hFF); m_en = '1;
    step('0, 8'hFF, "R6");
    step(8'h04, '0, "R5");
    wr(4'd5, 32'hFB); rd(4'd6, d); chk("R6", d, 32'h04);
    chk("R6", 32'(irq_out), 1);
    wr(4'd5, 32'h04); m_pend = '0; rd(4'd6, d); chk("R6", d, 0);
    chk("R6", 32'(irq_out), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule